// File: doc/BRIEF.md
# Two-Channel Phase-Offset Conversion Scheduler

This block times the end of each conversion window for two converter channels that take their samples at the same instants. Channel 1 is the timing reference: its window closes every `period` decimation ticks. The window of channel 0 is shifted by a signed tick count held in an 8-bit two's-complement phase register. A positive count makes channel 0 close its window later than channel 1, so channel 0 lags. A negative count makes channel 0 close earlier, so channel 0 leads. Only the grouping of samples into windows moves. The sampling instants stay the same for both channels.

When a window closes, the block raises a one-cycle conversion strobe for that channel and captures the channel's upstream filter result into a holding stage. One clock later it moves the held value to the output code and pulses that channel's data-ready line. A synchronous active-low hard reset clears the tick counter, both buffer stages, both output codes and the phase register. Phase writes made while the reset is low have no effect.

Top module: `dual_phase_sched`

## Requirements
- R1: While `hard_rst_n` is low, sampled at a rising clock edge, both output codes read zero and both strobes and both data-ready outputs are low after that edge. After reset the phase register holds zero.
- R2: A channel 1 conversion strobe is a single-cycle pulse. It rises in the clock after the tick that completes each run of `period` ticks, so consecutive channel 1 data-ready pulses are `period` ticks apart.
- R3: A data-ready output pulses for one cycle in the clock after its channel's conversion strobe. In that same cycle the channel's code changes to the filter input value sampled at the edge where the strobe rose.
- R4: With a phase code of zero, both data-ready outputs pulse in the same clock cycle.
- R5: With a positive phase code p, each channel 0 data-ready pulse comes exactly p ticks after the matching channel 1 pulse.
- R6: With a negative phase code -m, each channel 0 data-ready pulse comes exactly m ticks before the matching channel 1 pulse.
- R7: A phase magnitude of `period` or more is clamped to `period`-1 ticks. This includes the code 0x80, which reads as -128.
- R8: A phase value written with `phase_wr` becomes active at the next channel 1 window end. The channel 0 event at or before that boundary still uses the previous value.
- R9: A `phase_wr` made while `hard_rst_n` is low is ignored, so after reset the offset is zero.
- R10: Windows advance only on clock cycles where `tick` is high. With `tick` held low, no strobe and no data-ready pulse occurs once the events already in flight have come out.
- R11: Each output code holds its value in every cycle where its data-ready output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst_n | input | 1 | Synchronous active-low hard reset |
| tick | input | 1 | Decimation clock enable, one cycle per tick |
| period | input | CNT_W | Window length in ticks, at least 2 |
| phase_wr | input | 1 | Write strobe for the phase register |
| phase_wdata | input | 8 | Signed channel 0 offset in ticks (two's complement) |
| ch0_filt | input | DW | Upstream filter result, channel 0 |
| ch1_filt | input | DW | Upstream filter result, channel 1 |
| ch0_conv | output | 1 | Channel 0 window-end strobe |
| ch1_conv | output | 1 | Channel 1 window-end strobe |
| ch0_code | output | DW | Latched channel 0 output code |
| ch1_code | output | DW | Latched channel 1 output code |
| ch0_drdy | output | 1 | Channel 0 data-ready pulse |
| ch1_drdy | output | 1 | Channel 1 data-ready pulse |

## Verification
If the tick counter or the active phase value is wrong, the gap between the two data-ready lines drifts away from the programmed tick count. That error shows within one window of `period` ticks after the phase takes effect. If the target for a lead or lag case is off by one, the gap is off by exactly one tick, so the bench compares gaps in cycles with several tick rates. A fault in the holding stage or the output stage shows up as a code that does not equal the filter value from two cycles before the data-ready pulse, and it is caught at the first pulse.

// File: rtl/dps_pkg.sv
package dps_pkg;

    localparam int PHASE_W = 8;
    localparam int NCH     = 2;
    localparam int REF_CH  = 1;

    typedef logic signed [PHASE_W-1:0] phase_t;

    typedef struct packed {
        logic conv;
        logic drdy;
    } strobe_t;

    // Magnitude of a signed phase code. One extra bit holds 128.
    function automatic logic [PHASE_W:0] phase_mag(input phase_t p);
        logic signed [PHASE_W:0] wide;
        wide = {p[PHASE_W-1], p};
        return p[PHASE_W-1] ? (PHASE_W+1)'(-wide) : (PHASE_W+1)'(wide);
    endfunction

endpackage

// File: rtl/dps_phase_reg.sv
module dps_phase_reg
    import dps_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  phase_t           wdata,
    input  logic             load,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] tgt0
);
    localparam int MW = (CNT_W > PHASE_W + 1) ? CNT_W : PHASE_W + 1;

    phase_t         pend_q;
    phase_t         act_q;
    logic [MW-1:0]  mag;
    logic [MW-1:0]  pmax;
    logic [MW-1:0]  clip;
    logic [MW-1:0]  tgt_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            act_q  <= '0;
        end else begin
            if (wr)   pend_q <= wdata;
            if (load) act_q  <= pend_q;
        end
    end

    always_comb begin
        mag  = MW'(phase_mag(act_q));
        pmax = MW'(period) - MW'(1);
        clip = (mag > pmax) ? pmax : mag;
        if (act_q[PHASE_W-1])
            tgt_w = pmax - clip;
        else if (clip == '0)
            tgt_w = pmax;
        else
            tgt_w = clip - MW'(1);
        tgt0 = tgt_w[CNT_W-1:0];
    end

endmodule

// File: rtl/dps_timebase.sv
module dps_timebase
    import dps_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] tgt0,
    output logic [NCH-1:0]   ev
);
    logic [CNT_W-1:0] cnt_q;
    logic             wrap;

    assign wrap = (cnt_q >= period - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= wrap ? '0 : cnt_q + CNT_W'(1);
    end

    always_comb begin
        ev         = '0;
        ev[REF_CH] = tick && wrap;
        ev[0]      = tick && (cnt_q == tgt0);
    end

endmodule

// File: rtl/dps_chan_latch.sv
module dps_chan_latch
    import dps_pkg::*;
#(
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ev,
    input  logic [DW-1:0] filt,
    output strobe_t       stb,
    output logic [DW-1:0] code
);
    logic [DW-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stb    <= '0;
            hold_q <= '0;
            code   <= '0;
        end else begin
            stb.conv <= ev;
            stb.drdy <= stb.conv;
            if (ev)       hold_q <= filt;
            if (stb.conv) code   <= hold_q;
        end
    end

endmodule

// File: rtl/dual_phase_sched.sv
module dual_phase_sched
    import dps_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int DW    = 24
) (
    input  logic             clk,
    input  logic             hard_rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] period,
    input  logic             phase_wr,
    input  logic [7:0]       phase_wdata,
    input  logic [DW-1:0]    ch0_filt,
    input  logic [DW-1:0]    ch1_filt,
    output logic             ch0_conv,
    output logic             ch1_conv,
    output logic [DW-1:0]    ch0_code,
    output logic [DW-1:0]    ch1_code,
    output logic             ch0_drdy,
    output logic             ch1_drdy
);
    logic             rst;
    logic [CNT_W-1:0] tgt0;
    logic [NCH-1:0]   ev;
    logic [DW-1:0]    filt [NCH];
    logic [DW-1:0]    code [NCH];
    strobe_t          stb  [NCH];

    assign rst     = !hard_rst_n;
    assign filt[0] = ch0_filt;
    assign filt[1] = ch1_filt;

    dps_phase_reg #(.CNT_W(CNT_W)) u_phase (
        .clk    (clk),
        .rst    (rst),
        .wr     (phase_wr),
        .wdata  (phase_t'(phase_wdata)),
        .load   (ev[REF_CH]),
        .period (period),
        .tgt0   (tgt0)
    );

    dps_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .period (period),
        .tgt0   (tgt0),
        .ev     (ev)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dps_chan_latch #(.DW(DW)) u_lat (
            .clk  (clk),
            .rst  (rst),
            .ev   (ev[c]),
            .filt (filt[c]),
            .stb  (stb[c]),
            .code (code[c])
        );
    end

    assign ch0_conv = stb[0].conv;
    assign ch1_conv = stb[1].conv;
    assign ch0_drdy = stb[0].drdy;
    assign ch1_drdy = stb[1].drdy;
    assign ch0_code = code[0];
    assign ch1_code = code[1];

endmodule

// File: rtl/dps_checker.sv
module dps_checker #(
    parameter int DW = 24
) (
    input logic          clk,
    input logic          hard_rst_n,
    input logic          tick,
    input logic          ch0_conv,
    input logic          ch1_conv,
    input logic          ch0_drdy,
    input logic          ch1_drdy,
    input logic [DW-1:0] ch0_code,
    input logic [DW-1:0] ch1_code
);
    logic rst_seen_q;

    // R1: the edge after a sampled low reset leaves everything cleared
    always_ff @(posedge clk) begin
        if (rst_seen_q) begin
            p_reset_clear_r1: assert (ch0_code == '0 && ch1_code == '0 &&
                                      !ch0_drdy && !ch1_drdy &&
                                      !ch0_conv && !ch1_conv)
                else $error("reset did not clear outputs");
        end
        rst_seen_q <= !hard_rst_n;
    end

    // R2: reference strobe is a single pulse caused by a tick
    p_conv_tick_r2: assert property (@(posedge clk) disable iff (!hard_rst_n)
        ch1_conv |-> $past(tick));
    p_conv_pulse_r2: assert property (@(posedge clk) disable iff (!hard_rst_n)
        ch1_conv |=> !ch1_conv);

    // R3: data-ready follows its strobe by one clock
    p_drdy_after_conv0_r3: assert property (@(posedge clk) disable iff (!hard_rst_n)
        ch0_conv |=> ch0_drdy);
    p_drdy_after_conv1_r3: assert property (@(posedge clk) disable iff (!hard_rst_n)
        ch1_conv |=> ch1_drdy);

    // R11: codes only move with their data-ready pulse
    p_code_hold0_r11: assert property (@(posedge clk) disable iff (!hard_rst_n)
        !ch0_drdy |-> $stable(ch0_code));
    p_code_hold1_r11: assert property (@(posedge clk) disable iff (!hard_rst_n)
        !ch1_drdy |-> $stable(ch1_code));

endmodule

bind dual_phase_sched dps_checker #(.DW(DW)) u_chk (
    .clk        (clk),
    .hard_rst_n (hard_rst_n),
    .tick       (tick),
    .ch0_conv   (ch0_conv),
    .ch1_conv   (ch1_conv),
    .ch0_drdy   (ch0_drdy),
    .ch1_drdy   (ch1_drdy),
    .ch0_code   (ch0_code),
    .ch1_code   (ch1_code)
);

// File: tb/tb_dual_phase_sched.sv
module tb_dual_phase_sched;
    localparam int CLK_NS = 10;
    localparam int CNT_W  = 8;
    localparam int DW     = 24;

    typedef struct packed {
        int p;
        int ph;
        int div;
        int gap;
    } vec_t;

    // period, phase code, tick divider, expected ch0-minus-ch1 gap in ticks
    localparam vec_t VECS [8] = '{
        '{8,    0, 1,  0},
        '{8,    3, 1,  3},
        '{8,   -3, 1, -3},
        '{10,   5, 2,  5},
        '{6,   -5, 3, -5},
        '{8,  100, 1,  7},
        '{8, -128, 1, -7},
        '{16,   1, 1,  1}
    };

    logic             clk = 1'b0;
    logic             hard_rst_n = 1'b0;
    logic             tick = 1'b0;
    logic [CNT_W-1:0] period = 8'd8;
    logic             phase_wr = 1'b0;
    logic [7:0]       phase_wdata = '0;
    logic [DW-1:0]    ch0_filt = '0;
    logic [DW-1:0]    ch1_filt = '0;
    logic             ch0_conv, ch1_conv, ch0_drdy, ch1_drdy;
    logic [DW-1:0]    ch0_code, ch1_code;

    int cyc = 0, n_chk = 0, n_bad = 0;
    int t0 = -1000, t1 = -1000, c0 = 0, c1 = 0;
    int tick_div = 1;
    bit tick_en = 1'b0;

    dual_phase_sched #(.CNT_W(CNT_W), .DW(DW)) dut (
        .clk(clk), .hard_rst_n(hard_rst_n), .tick(tick), .period(period),
        .phase_wr(phase_wr), .phase_wdata(phase_wdata),
        .ch0_filt(ch0_filt), .ch1_filt(ch1_filt),
        .ch0_conv(ch0_conv), .ch1_conv(ch1_conv),
        .ch0_code(ch0_code), .ch1_code(ch1_code),
        .ch0_drdy(ch0_drdy), .ch1_drdy(ch1_drdy)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // input driver: ticks and filter values change at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            tick     <= tick_en && (cyc % tick_div == 0);
            ch0_filt <= 24'h100000 + DW'(cyc);
            ch1_filt <= 24'h200000 + DW'(cyc);
        end
    end

    // monitor: one time unit after each rising edge
    always @(posedge clk) begin
        #1;
        cyc++;
        if (ch0_drdy) begin
            t0 = cyc; c0++;
            chk("R3 ch0 code", ch0_code, 24'h100000 + DW'(cyc - 2));
        end
        if (ch1_drdy) begin
            t1 = cyc; c1++;
            chk("R3 ch1 code", ch1_code, 24'h200000 + DW'(cyc - 2));
        end
    end

    task automatic do_reset();
        @(negedge clk); hard_rst_n = 1'b0;
        repeat (3) @(negedge clk);
        hard_rst_n = 1'b1;
    endtask

    task automatic wait1();
        int n = c1;
        while (c1 == n) @(negedge clk);
    endtask

    task automatic wait0();
        int n = c0;
        while (c0 == n) @(negedge clk);
    endtask

    task automatic write_phase(input int v);
        @(negedge clk); phase_wr = 1'b1; phase_wdata = 8'(v);
        @(negedge clk); phase_wr = 1'b0;
    endtask

    task automatic measure(input string tag, input int p, input int g, input int div);
        int tp;
        wait1();
        tp = t1;
        wait1();
        chk("R2 ch1 spacing", t1 - tp, p * div);
        if (g > 0) begin
            wait0();
            chk(tag, t0 - t1, g * div);
        end else begin
            chk(tag, t0 - t1, g * div);
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        do_reset();
        @(negedge clk);
        // R1: reset state
        chk("R1 ch0 code", ch0_code, 0);
        chk("R1 ch1 code", ch1_code, 0);
        chk("R1 strobes", {ch0_conv, ch1_conv, ch0_drdy, ch1_drdy}, 0);

        foreach (VECS[i]) begin
            string tag;
            tick_en  = 1'b0;
            do_reset();
            period   = CNT_W'(VECS[i].p);
            tick_div = VECS[i].div;
            tick_en  = 1'b1;
            write_phase(VECS[i].ph);
            wait1();
            if (VECS[i].gap == 0)
                tag = "R4 zero phase gap";
            else if (VECS[i].ph >= VECS[i].p || -VECS[i].ph >= VECS[i].p)
                tag = "R7 clamped gap";
            else if (VECS[i].gap > 0)
                tag = "R5 lag gap";
            else
                tag = "R6 lead gap";
            measure(tag, VECS[i].p, VECS[i].gap, VECS[i].div);
        end

        // R9: write during reset is ignored
        tick_en = 1'b0;
        @(negedge clk); hard_rst_n = 1'b0;
        write_phase(5);
        @(negedge clk); hard_rst_n = 1'b1;
        period = 8'd8; tick_div = 1; tick_en = 1'b1;
        measure("R9 write in reset ignored", 8, 0, 1);

        // R8: new value waits for the next channel 1 boundary
        write_phase(4);
        wait1();
        chk("R8 old phase at boundary", t0 - t1, 0);
        wait0();
        chk("R8 new phase after boundary", t0 - t1, 4);

        // R10 / R11: stall with tick low
        begin
            int s0, s1;
            logic [DW-1:0] k0, k1;
            tick_en = 1'b0;
            repeat (4) @(negedge clk);
            s0 = c0; s1 = c1; k0 = ch0_code; k1 = ch1_code;
            repeat (40) @(negedge clk);
            chk("R10 no ch0 event while stalled", c0 - s0, 0);
            chk("R10 no ch1 event while stalled", c1 - s1, 0);
            chk("R11 ch0 code held", ch0_code, k0);
            chk("R11 ch1 code held", ch1_code, k1);
        end

        // R1: reset in the middle of operation
        tick_en = 1'b1;
        wait1();
        @(negedge clk); hard_rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-run ch0 code", ch0_code, 0);
        chk("R1 mid-run ch1 code", ch1_code, 0);
        chk("R1 mid-run strobes", {ch0_conv, ch1_conv, ch0_drdy, ch1_drdy}, 0);
        hard_rst_n = 1'b1;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_NS * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule